// File: doc/BRIEF.md
# Word-Filled, Byte-Drained Instruction Prefetch Queue

This block buffers instruction bytes between a 16-bit bus and a byte-wide instruction decoder. Three word slots hold up to six bytes. The bus side writes one whole word at a time, and the decoder side takes one byte at a time. Inside a word, the low byte always goes out before the high byte.

The queue asks for another word whenever it has room for one. It holds that request until the shared bus grants it, and a grant strobe carries the data in the same cycle. When control transfers elsewhere, a flush empties the queue. If the new target address is odd, the low byte of the first word that arrives after the flush is skipped.

Because fetching runs ahead of execution, the block reports how many bytes it holds. It also reports the negated count, which is the value to add to the run-ahead fetch address to get the true instruction pointer.

Top module: `prefetch_queue`

## Requirements
- R1: After reset, the queue is empty. `queueCount` is 0, `byteValid` is 0, `ipCorrection` is 0 and `fetchReq` is 1.
- R2: `fetchReq` is 1 exactly when at least two bytes of the six are free and `flushReq` is low. A `fetchGrant` in a cycle where `fetchReq` is low stores nothing.
- R3: Bytes leave in arrival order. Each word gives its low byte (bits 7:0) first and then its high byte (bits 15:8). The read side moves to the next word only after the high byte has been taken.
- R4: The three slots are used in the rotating order 0, 1, 2, 0. Three words written without reads give a full queue of six bytes, which is reported as full and never as empty.
- R5: `queueCount` (0 to 6) always equals the number of bytes stored and not yet taken.
- R6: `ipCorrection` is a 4-bit two's-complement value equal to minus `queueCount`. It is 0 when the queue is empty, -1 (4'hF) for one byte, and so on down to -6 (4'hA).
- R7: A cycle with `flushReq` high leaves the queue empty in the next cycle. `fetchReq` is low during that cycle, and a `fetchGrant` in the same cycle is discarded.
- R8: A flush with `flushOdd` high drops the low byte of the first word written after it. The next byte delivered is that word's high byte, and `queueCount` goes from 0 to 1.
- R9: A word write and a byte read in the same cycle both take effect, and `queueCount` rises by exactly 1.
- R10: `byteValid` is low whenever the queue is empty. A `byteTake` while empty changes neither the count nor the bytes delivered later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flushReq | input | 1 | Discard all queued bytes (control transfer) |
| flushOdd | input | 1 | The flush target address is odd |
| fetchReq | output | 1 | Request for one more word from the bus |
| fetchGrant | input | 1 | Bus grant; `fetchData` is valid in this cycle |
| fetchData | input | 16 | Fetched instruction word |
| byteValid | output | 1 | `byteData` holds a queued byte |
| byteData | output | 8 | Oldest queued byte |
| byteTake | input | 1 | Decoder consumes `byteData` |
| queueCount | output | 3 | Number of queued bytes |
| ipCorrection | output | 4 | Minus `queueCount`, two's complement |

## Verification
The hardest states to reach from the ports are the boundaries where several events land on one edge. Examples are a grant in the same cycle as a flush, an odd flush followed at once by a word write and a read, and a read that frees a slot at the moment the queue is full. Directed sequences put the queue into each of these states. A long stretch of pseudo-random grants, reads and occasional odd or even flushes follows. On every cycle, all outputs are compared against a byte-list model kept in the bench.

// File: rtl/pq_pkg.sv
package pq_pkg;
  localparam int PQ_SLOTS = 3;
  localparam int PQ_PTR_W = $clog2(PQ_SLOTS);

  // Strobes from control to datapath
  typedef struct packed {
    logic                writeEn;
    logic [PQ_PTR_W-1:0] writeSlot;
    logic [PQ_PTR_W-1:0] readSlot;
    logic                readHi;
  } pq_strobe_t;
endpackage

// File: rtl/pq_ctrl.sv
module pq_ctrl
  import pq_pkg::*;
#(
  parameter int SLOTS = PQ_SLOTS,
  localparam int PTR_W = PQ_PTR_W,
  localparam int CAP = 2 * SLOTS,
  localparam int CNT_W = $clog2(CAP + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    flushReq,
  input  logic                    flushOdd,
  input  logic                    fetchGrant,
  input  logic                    byteTake,
  output logic                    fetchReq,
  output logic                    byteValid,
  output logic [CNT_W-1:0]        queueCount,
  output logic signed [CNT_W:0]   ipCorrection,
  output pq_strobe_t              strobes
);

  logic [PTR_W-1:0] rdPtr, wrPtr, rdNext, wrNext;
  logic hiSel, hiNext, emptyQ, emptyNext;
  logic full, doWrite, doRead, endWord;
  logic [CNT_W-1:0] wordsHeld, countBytes;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full = !emptyQ && (rdPtr == wrPtr);

  always_comb begin
    if (emptyQ)              wordsHeld = '0;
    else if (full)           wordsHeld = CNT_W'(SLOTS);
    else if (wrPtr > rdPtr)  wordsHeld = CNT_W'(wrPtr - rdPtr);
    else                     wordsHeld = CNT_W'(SLOTS) - CNT_W'(rdPtr) + CNT_W'(wrPtr);
  end

  assign countBytes = emptyQ ? '0 : ({wordsHeld[CNT_W-2:0], 1'b0} - CNT_W'(hiSel));

  assign doWrite = fetchGrant && !flushReq && !full;
  assign doRead  = byteTake && !emptyQ;
  assign endWord = doRead && hiSel;

  always_comb begin
    rdNext = endWord ? stepPtr(rdPtr) : rdPtr;
    wrNext = doWrite ? stepPtr(wrPtr) : wrPtr;
    if (flushReq) begin
      rdNext = '0;
      wrNext = '0;
      hiNext = flushOdd;
      emptyNext = 1'b1;
    end else begin
      hiNext = doRead ? !hiSel : hiSel;
      if (doWrite)                                  emptyNext = 1'b0;
      else if (endWord && stepPtr(rdPtr) == wrPtr)  emptyNext = 1'b1;
      else                                          emptyNext = emptyQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr  <= '0;
      wrPtr  <= '0;
      hiSel  <= 1'b0;
      emptyQ <= 1'b1;
    end else begin
      rdPtr  <= rdNext;
      wrPtr  <= wrNext;
      hiSel  <= hiNext;
      emptyQ <= emptyNext;
    end
  end

  assign fetchReq     = !full && !flushReq;
  assign byteValid    = !emptyQ;
  assign queueCount   = countBytes;
  assign ipCorrection = -$signed({1'b0, countBytes});

  always_comb begin
    strobes.writeEn   = doWrite;
    strobes.writeSlot = wrPtr;
    strobes.readSlot  = rdPtr;
    strobes.readHi    = hiSel;
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    (countBytes == CNT_W'(CAP)) |-> !fetchReq);
  assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdPtr < PTR_W'(SLOTS)) && (wrPtr < PTR_W'(SLOTS)));
  assert_count_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    countBytes <= CNT_W'(CAP));
  assert_odd_preset_R8: assert property (@(posedge clk) disable iff (!rstN)
    (flushReq && flushOdd) |=> (hiSel && emptyQ));
  assert_both_honoured_R9: assert property (@(posedge clk) disable iff (!rstN)
    (doWrite && doRead) |=> (countBytes == $past(countBytes) + 1'b1));
  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchGrant && !flushReq && (!byteTake || emptyQ)) |=> $stable(countBytes));
endmodule

// File: rtl/pq_data.sv
module pq_data
  import pq_pkg::*;
#(
  parameter int SLOTS = PQ_SLOTS,
  parameter int WORD_W = 16,
  localparam int BYTE_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  pq_strobe_t        strobes,
  input  logic [WORD_W-1:0] wordIn,
  output logic [BYTE_W-1:0] byteOut
);

  logic [SLOTS-1:0][WORD_W-1:0] slotQ;
  logic [WORD_W-1:0] curWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotQ <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (strobes.writeEn && strobes.writeSlot == PQ_PTR_W'(s)) slotQ[s] <= wordIn;
      end
    end
  end

  always_comb begin
    curWord = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (strobes.readSlot == PQ_PTR_W'(s)) curWord = slotQ[s];
    end
  end

  assign byteOut = strobes.readHi ? curWord[WORD_W-1:BYTE_W] : curWord[BYTE_W-1:0];
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pq_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int BYTE_W = WORD_W / 2,
  localparam int CNT_W = $clog2(2 * PQ_SLOTS + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  flushReq,
  input  logic                  flushOdd,
  output logic                  fetchReq,
  input  logic                  fetchGrant,
  input  logic [WORD_W-1:0]     fetchData,
  output logic                  byteValid,
  output logic [BYTE_W-1:0]     byteData,
  input  logic                  byteTake,
  output logic [CNT_W-1:0]      queueCount,
  output logic signed [CNT_W:0] ipCorrection
);

  pq_strobe_t strobes;

  pq_ctrl #(.SLOTS(PQ_SLOTS)) ctrl_i (
    .clk(clk), .rstN(rstN), .flushReq(flushReq), .flushOdd(flushOdd),
    .fetchGrant(fetchGrant), .byteTake(byteTake), .fetchReq(fetchReq),
    .byteValid(byteValid), .queueCount(queueCount),
    .ipCorrection(ipCorrection), .strobes(strobes)
  );

  pq_data #(.SLOTS(PQ_SLOTS), .WORD_W(WORD_W)) data_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wordIn(fetchData),
    .byteOut(byteData)
  );

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> (queueCount == '0 && !byteValid));
  assert_empty_novalid_R10: assert property (@(posedge clk) disable iff (!rstN)
    (queueCount == '0) == !byteValid);
endmodule

// File: tb/prefetch_queue_tb.sv
module prefetch_queue_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flushReq = 1'b0, flushOdd = 1'b0, fetchGrant = 1'b0, byteTake = 1'b0;
  logic [15:0] fetchData = '0;
  logic fetchReq, byteValid;
  logic [7:0] byteData;
  logic [2:0] queueCount;
  logic signed [3:0] ipCorrection;

  int checks = 0;
  int fails = 0;
  int q[$];
  bit skipLow = 0;

  always #5 clk = ~clk;

  prefetch_queue dut_i (
    .clk(clk), .rstN(rstN), .flushReq(flushReq), .flushOdd(flushOdd),
    .fetchReq(fetchReq), .fetchGrant(fetchGrant), .fetchData(fetchData),
    .byteValid(byteValid), .byteData(byteData), .byteTake(byteTake),
    .queueCount(queueCount), .ipCorrection(ipCorrection)
  );

  task automatic expect_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    int sz = q.size();
    expect_eq("R2 fetchReq", int'(fetchReq), int'((6 - sz) >= 2 && !flushReq));
    expect_eq("R10 byteValid", int'(byteValid), int'(sz > 0));
    expect_eq("R5 queueCount", int'(queueCount), sz);
    expect_eq("R6 ipCorrection", int'(ipCorrection), -sz);
    if (sz > 0) expect_eq("R3 byteData", int'(byteData), q[0]);
  endtask

  // One clock: drive at negedge, compare, update model at posedge
  task automatic step(bit f, bit o, bit g, logic [15:0] d, bit t);
    bit room;
    bit valid;
    flushReq = f; flushOdd = o; fetchGrant = g; fetchData = d; byteTake = t;
    #1;
    compare_model();
    room = (6 - q.size()) >= 2;
    valid = q.size() > 0;
    @(posedge clk);
    if (f) begin
      q.delete();
      skipLow = o;
    end else begin
      if (t && valid) void'(q.pop_front());
      if (g && room) begin
        if (!skipLow) q.push_back(int'(d[7:0]));
        skipLow = 0;
        q.push_back(int'(d[15:8]));
      end
    end
    @(negedge clk);
  endtask

  task automatic settle();
    flushReq = 0; flushOdd = 0; fetchGrant = 0; byteTake = 0;
    #1;
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed = 7;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
    // R1 reset state
    expect_eq("R1 count", int'(queueCount), 0);
    expect_eq("R1 valid", int'(byteValid), 0);
    expect_eq("R1 corr", int'(ipCorrection), 0);
    expect_eq("R1 req", int'(fetchReq), 1);

    // R4 fill three words
    step(0, 0, 1, 16'h2211, 0);
    step(0, 0, 1, 16'h4433, 0);
    step(0, 0, 1, 16'h6655, 0);
    settle();
    expect_eq("R4 full count", int'(queueCount), 6);
    expect_eq("R4 full valid", int'(byteValid), 1);
    expect_eq("R2 full req", int'(fetchReq), 0);
    expect_eq("R6 corr -6", int'(ipCorrection), -6);
    // R2 grant while full is ignored
    step(0, 0, 1, 16'hEEEE, 0);
    // R3 drain in order
    for (int i = 0; i < 6; i++) begin
      settle();
      expect_eq("R3 order", int'(byteData), 8'h11 * (i + 1));
      step(0, 0, 0, 16'h0, 1);
    end
    settle();
    expect_eq("R10 empty after drain", int'(byteValid), 0);
    // R10 reads while empty ignored
    step(0, 0, 0, 16'h0, 1);
    step(0, 0, 0, 16'h0, 1);
    step(0, 0, 1, 16'hB2A1, 0);
    settle();
    expect_eq("R10 first byte after idle reads", int'(byteData), 8'hA1);
    // R9 simultaneous write and read
    step(0, 0, 1, 16'hD4C3, 1);
    settle();
    expect_eq("R9 count +1", int'(queueCount), 3);
    // R7 flush with grant in same cycle
    settle();
    flushReq = 1;
    #1;
    expect_eq("R7 req low in flush", int'(fetchReq), 0);
    step(1, 0, 1, 16'h9999, 0);
    settle();
    expect_eq("R7 empty after flush", int'(queueCount), 0);
    // R8 odd flush, then write with read
    step(1, 1, 0, 16'h0, 0);
    step(0, 0, 1, 16'h7F70, 1);
    settle();
    expect_eq("R8 count 1", int'(queueCount), 1);
    expect_eq("R8 high byte first", int'(byteData), 8'h7F);
    step(0, 0, 1, 16'h8180, 1);
    // fill to the 5-byte boundary after odd flush
    step(0, 0, 1, 16'h8382, 0);
    step(0, 0, 1, 16'h8584, 0);
    step(0, 0, 1, 16'h8786, 1);

    // pseudo-random phase
    void'($urandom(seed));
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom() % 100);
      step(r < 3, r[0], ($urandom() % 3) != 0, 16'($urandom()), ($urandom() % 2) == 1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule